// File: doc/BRIEF.md
# Transmit-Only Display-Identification Memory Streamer

This block provides the clock-driven, read-only output path of a 128-byte serial identification memory of the kind a display presents to its host. After reset it listens on a dedicated streaming clock input, `vclk_in`. It streams the stored bytes out on a serial data line. There is no addressing protocol: the host supplies clock edges and receives data. Nine initialization clocks come first. During the first eight of them, the level the host leaves on the data line picks where the stream starts, either at the top byte or at the bottom byte.

Each byte goes out as a nine-period frame. Eight data bits are sent, the most significant bit first. A ninth period follows, during which the line is released. The address then moves on by one and wraps from the top of the array back to zero.

The block samples all three line inputs against a fast system clock through two-flop synchronizers. It drives the data line as a value together with an output enable. The array is filled through a parallel preload port, which takes effect only while reset is held. The bidirectional command clock `scl_in` must stay high. Its first falling edge ends streaming for good and raises a sticky exit flag.

Top module: `ddc_stream_top`

## Requirements
- R1: From reset until the ninth synchronized rising edge of `vclk_in`, `sda_oe` stays 0.
- R2: The start address is 0x7F if `sda_in` was high when the eighth initialization clock was sampled. It is 0x00 if `sda_in` was low then.
- R3: `sda_oe` remains 0 after the ninth initialization clock. That edge only finishes initialization.
- R4: Each byte takes nine `vclk_in` rising edges. Edges one to eight each present the next data bit, from bit 7 down to bit 0, on `sda_out` with `sda_oe` = 1. Edge nine sets `sda_oe` = 0 for the don't-care period.
- R5: Consecutive frames carry consecutive addresses with no idle frame between them.
- R6: The frame that follows the byte at address 0x7F carries the byte at address 0x00.
- R7: If `sda_in` changes level across the first eight initialization clocks, only the level sampled on the eighth clock decides the start address.
- R8: A falling edge on the synchronized `scl_in`, in initialization or in streaming, forces `sda_oe` to 0 and sets `mode_exit` to 1. `mode_exit` then stays 1 until reset, and later `vclk_in` edges have no effect on `sda_oe`.
- R9: A preload write (`pl_we` = 1) stores `pl_data` at `pl_addr` only while `rst_n` is 0. While `rst_n` is 1, a preload write leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the streaming clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vclk_in | input | 1 | Asynchronous streaming clock from the host |
| scl_in | input | 1 | Asynchronous command clock. It must stay high to keep streaming |
| sda_in | input | 1 | Asynchronous level of the data line |
| sda_out | output | 1 | Data bit driven when `sda_oe` is 1. It reads 1 when the line is released |
| sda_oe | output | 1 | Output enable for the data line |
| mode_exit | output | 1 | Sticky flag: a falling edge on the command clock ended streaming |
| pl_we | input | 1 | Preload write strobe. It takes effect only in reset |
| pl_addr | input | 7 | Preload address |
| pl_data | input | 8 | Preload data |

## Verification
The bench covers both start-address choices. It also drives mixed-level patterns on the data line during initialization. A design that latched the first sample, or that sampled on the ninth clock, would start the stream at the wrong end of the array.

The bench counts each bit period and checks that the line is released on the ninth initialization clock and on every ninth frame period. A bit-counter off-by-one would show up as a shifted or missing bit. Streaming from 0x7F into 0x00 catches a design that stops or skips at the array boundary.

The command-clock fall is applied both during initialization and in the middle of a byte, and streaming clocks are then kept going. A non-sticky exit, or one that drove the line again, would be seen. A preload write after reset release checks that the array cannot change while the block runs.

// File: rtl/ddc_pkg.sv
// Package: shared mode encoding for the transmit-only streamer.
// Assumes: nothing; holds types only.
package ddc_pkg;
    typedef enum logic [1:0] {
        MODE_INIT   = 2'd0,
        MODE_STREAM = 2'd1,
        MODE_EXIT   = 2'd2
    } mode_t;
endpackage

// File: rtl/ddc_sync.sv
// Module: ddc_sync
// Brings one asynchronous line into the clk domain through a flop chain
// and flags rising and falling edges of the synchronized value.
// Assumes: the input is slow compared with clk (several clk cycles per level).
module ddc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw input through the synchronizer chain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    // Expose level and single-cycle edge strobes.
    always_comb begin
        level = chain[STAGES-1];
        rise  = chain[STAGES-1] & ~prev;
        fall  = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/ddc_store.sv
// Module: ddc_store
// Register array holding the identification bytes, with asynchronous read.
// Assumes: the preload port is meaningful only while rst_n is low; writes
// at any other time are dropped.
module ddc_store #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pl_we,
    input  logic [ADDR_W-1:0] pl_addr,
    input  logic [DATA_W-1:0] pl_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Accept preload writes only while the block is held in reset.
    always_ff @(posedge clk) begin
        if (!rst_n && pl_we) begin
            cells[pl_addr] <= pl_data;
        end
    end

    // Present the addressed byte combinationally.
    always_comb begin
        rd_data = cells[rd_addr];
    end
endmodule

// File: rtl/ddc_seq.sv
// Module: ddc_seq
// Mode sequencer: counts initialization clocks, picks the start address,
// walks bit positions and addresses, and handles the command-clock abort.
// Assumes: edge strobes are single-cycle and come from synchronized lines.
module ddc_seq
    import ddc_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int INIT_CLKS = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      vclk_rise,
    input  logic                      scl_fall,
    input  logic                      sda_level,
    output logic [ADDR_W-1:0]         rd_addr,
    output logic [$clog2(DATA_W)-1:0] bit_pos,
    output logic                      drive_en,
    output logic                      exit_flag
);
    localparam int BIT_W  = $clog2(DATA_W + 1);
    localparam int INIT_W = $clog2(INIT_CLKS + 1);
    localparam int POS_W  = $clog2(DATA_W);

    mode_t             mode;
    logic [INIT_W-1:0] init_cnt;
    logic [BIT_W-1:0]  frame_pos;
    logic              start_top;

    // Advance the mode, initialization count, frame position and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= MODE_INIT;
            init_cnt  <= '0;
            frame_pos <= BIT_W'(DATA_W);
            start_top <= 1'b0;
            rd_addr   <= '0;
            exit_flag <= 1'b0;
        end else begin
            case (mode)
                MODE_INIT: begin
                    if (scl_fall) begin
                        mode      <= MODE_EXIT;
                        exit_flag <= 1'b1;
                    end else if (vclk_rise) begin
                        if (init_cnt == INIT_W'(INIT_CLKS - 1)) begin
                            mode      <= MODE_STREAM;
                            frame_pos <= BIT_W'(DATA_W);
                            rd_addr   <= (start_top ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}})
                                         - ADDR_W'(1);
                        end else begin
                            init_cnt  <= init_cnt + INIT_W'(1);
                            start_top <= sda_level;
                        end
                    end
                end
                MODE_STREAM: begin
                    if (scl_fall) begin
                        mode      <= MODE_EXIT;
                        exit_flag <= 1'b1;
                    end else if (vclk_rise) begin
                        if (frame_pos == BIT_W'(DATA_W)) begin
                            frame_pos <= '0;
                            rd_addr   <= rd_addr + ADDR_W'(1);
                        end else begin
                            frame_pos <= frame_pos + BIT_W'(1);
                        end
                    end
                end
                default: begin
                    mode      <= MODE_EXIT;
                    exit_flag <= 1'b1;
                end
            endcase
        end
    end

    // Drive only during data periods of a frame; map position to bit index.
    always_comb begin
        drive_en = (mode == MODE_STREAM) && (frame_pos != BIT_W'(DATA_W));
        bit_pos  = drive_en ? POS_W'(DATA_W - 1 - int'(frame_pos)) : '0;
    end
endmodule

// File: rtl/ddc_stream_top.sv
// Module: ddc_stream_top
// Transmit-only streamer for a 128-byte identification memory. Synchronizes
// the three line inputs, sequences initialization and streaming, and drives
// the data line as value plus enable.
// Assumes: clk is much faster than vclk_in; preload happens during reset.
module ddc_stream_top #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int INIT_CLKS   = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vclk_in,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_out,
    output logic              sda_oe,
    output logic              mode_exit,
    input  logic              pl_we,
    input  logic [ADDR_W-1:0] pl_addr,
    input  logic [DATA_W-1:0] pl_data
);
    localparam int   N_LINES  = 3;
    localparam int   POS_W    = $clog2(DATA_W);
    // Line order: 0 = streaming clock, 1 = command clock (idles high), 2 = data.
    localparam logic [N_LINES-1:0] LINE_RST = 3'b010;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_level;
    logic [N_LINES-1:0] sync_rise;
    logic [N_LINES-1:0] sync_fall;

    logic [ADDR_W-1:0]  rd_addr;
    logic [DATA_W-1:0]  rd_data;
    logic [POS_W-1:0]   bit_pos;
    logic               drive_en;
    logic               vclk_rise;
    logic               scl_fall;

    assign raw_lines = {sda_in, scl_in, vclk_in};

    genvar g;
    generate
        for (g = 0; g < N_LINES; g++) begin : g_sync
            ddc_sync #(
                .STAGES (SYNC_STAGES),
                .RST_VAL(LINE_RST[g])
            ) sync_i (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (raw_lines[g]),
                .level(sync_level[g]),
                .rise (sync_rise[g]),
                .fall (sync_fall[g])
            );
        end
    endgenerate

    assign vclk_rise = sync_rise[0];
    assign scl_fall  = sync_fall[1];

    ddc_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pl_we  (pl_we),
        .pl_addr(pl_addr),
        .pl_data(pl_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    ddc_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .INIT_CLKS(INIT_CLKS)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .vclk_rise(vclk_rise),
        .scl_fall (scl_fall),
        .sda_level(sync_level[2]),
        .rd_addr  (rd_addr),
        .bit_pos  (bit_pos),
        .drive_en (drive_en),
        .exit_flag(mode_exit)
    );

    // Form the data line outputs; the value idles high when released.
    always_comb begin
        sda_oe  = drive_en;
        sda_out = drive_en ? rd_data[bit_pos] : 1'b1;
    end
endmodule

// File: rtl/ddc_stream_chk.sv
// Module: ddc_stream_chk
// Protocol checker bound to ddc_stream_top.
// Assumes: vclk_rise and scl_fall are the synchronized edge strobes.
module ddc_stream_chk #(
    parameter int INIT_CLKS = 9
) (
    input logic clk,
    input logic rst_n,
    input logic vclk_rise,
    input logic scl_fall,
    input logic sda_oe,
    input logic mode_exit
);
    localparam int CW = $clog2(INIT_CLKS + 1);

    logic [CW-1:0] rise_seen;

    // Count streaming-clock edges since reset, saturating at the init length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_seen <= '0;
        end else if (vclk_rise && rise_seen != CW'(INIT_CLKS)) begin
            rise_seen <= rise_seen + CW'(1);
        end
    end

    AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_seen < CW'(INIT_CLKS)) |-> !sda_oe);                          // R1
    AST_OE_FOLLOWS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(vclk_rise));                                 // R4
    AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!vclk_rise && !scl_fall) |=> $stable(sda_oe));                      // R4
    AST_SCL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> mode_exit);                                             // R8
    AST_EXIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_exit |=> mode_exit);                                            // R8
    AST_EXIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_exit |-> !sda_oe);                                              // R8
endmodule

bind ddc_stream_top ddc_stream_chk #(
    .INIT_CLKS(INIT_CLKS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .vclk_rise(vclk_rise),
    .scl_fall (scl_fall),
    .sda_oe   (sda_oe),
    .mode_exit(mode_exit)
);

// File: tb/ddc_stream_top_tb_top.sv
// Bench: directed scenarios for ddc_stream_top, one task each.
module ddc_stream_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vclk_in = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b0;
    logic       sda_out;
    logic       sda_oe;
    logic       mode_exit;
    logic       pl_we = 1'b0;
    logic [6:0] pl_addr = '0;
    logic [7:0] pl_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ddc_stream_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .vclk_in  (vclk_in),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_out  (sda_out),
        .sda_oe   (sda_oe),
        .mode_exit(mode_exit),
        .pl_we    (pl_we),
        .pl_addr  (pl_addr),
        .pl_data  (pl_data)
    );

    function automatic logic [7:0] pattern_byte(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold reset, load the array, release reset.
    task automatic reset_and_load();
        @(negedge clk);
        rst_n   = 1'b0;
        vclk_in = 1'b0;
        scl_in  = 1'b1;
        sda_in  = 1'b0;
        for (int a = 0; a < 128; a++) begin
            pl_we   = 1'b1;
            pl_addr = 7'(a);
            pl_data = pattern_byte(a);
            @(negedge clk);
        end
        pl_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // One full streaming clock period; outputs settle well within it.
    task automatic vpulse();
        vclk_in = 1'b1;
        repeat (6) @(negedge clk);
        vclk_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Nine initialization clocks; pat[7] goes with the first clock.
    task automatic run_init(input logic [7:0] pat);
        for (int i = 0; i < 8; i++) begin
            sda_in = pat[7-i];
            vpulse();
            check("R1 oe during init", int'(sda_oe), 0);
        end
        sda_in = 1'b0;
        vpulse();
        check("R3 oe after ninth init clock", int'(sda_oe), 0);
    endtask

    // Receive one nine-period frame and compare with the expected byte.
    task automatic take_byte(input logic [7:0] exp, input string req);
        for (int b = 7; b >= 0; b--) begin
            vpulse();
            check({req, " R4 oe in data bit"}, int'(sda_oe), 1);
            check({req, " R4 data bit"}, int'(sda_out), int'(exp[b]));
        end
        vpulse();
        check({req, " R4 oe in dont-care period"}, int'(sda_oe), 0);
    endtask

    task automatic t_reset();
        reset_and_load();
        check("R1 reset oe", int'(sda_oe), 0);
        check("R8 reset exit flag", int'(mode_exit), 0);
    endtask

    task automatic t_start_low();
        reset_and_load();
        run_init(8'h00);
        take_byte(pattern_byte(0), "R2 start low");
        take_byte(pattern_byte(1), "R5 next byte");
        take_byte(pattern_byte(2), "R5 third byte");
    endtask

    task automatic t_start_high_wrap();
        reset_and_load();
        run_init(8'hFF);
        take_byte(pattern_byte(127), "R2 start high");
        take_byte(pattern_byte(0), "R6 wrap");
        take_byte(pattern_byte(1), "R6 after wrap");
    endtask

    task automatic t_mixed();
        reset_and_load();
        run_init(8'b1111_1110);
        take_byte(pattern_byte(0), "R7 eighth low");
        reset_and_load();
        run_init(8'b0000_0001);
        take_byte(pattern_byte(127), "R7 eighth high");
    endtask

    task automatic t_exit_stream();
        reset_and_load();
        run_init(8'h00);
        take_byte(pattern_byte(0), "R5 pre-exit");
        for (int i = 0; i < 3; i++) vpulse();
        check("R4 mid-byte oe", int'(sda_oe), 1);
        scl_in = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 oe after scl fall", int'(sda_oe), 0);
        check("R8 exit flag", int'(mode_exit), 1);
        scl_in = 1'b1;
        for (int i = 0; i < 12; i++) begin
            vpulse();
            check("R8 oe ignores vclk", int'(sda_oe), 0);
        end
        check("R8 exit sticky", int'(mode_exit), 1);
    endtask

    task automatic t_exit_init();
        reset_and_load();
        for (int i = 0; i < 4; i++) vpulse();
        scl_in = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 exit during init", int'(mode_exit), 1);
        scl_in = 1'b1;
        for (int i = 0; i < 16; i++) vpulse();
        check("R8 oe stays low after init exit", int'(sda_oe), 0);
        check("R8 exit still set", int'(mode_exit), 1);
    endtask

    task automatic t_preload_ignored();
        reset_and_load();
        pl_we   = 1'b1;
        pl_addr = 7'd0;
        pl_data = ~pattern_byte(0);
        @(negedge clk);
        pl_addr = 7'd127;
        pl_data = ~pattern_byte(127);
        @(negedge clk);
        pl_we = 1'b0;
        run_init(8'hFF);
        take_byte(pattern_byte(127), "R9 preload ignored at 0x7F");
        take_byte(pattern_byte(0), "R9 preload ignored at 0x00");
    endtask

    initial begin
        t_reset();
        t_start_low();
        t_start_high_wrap();
        t_mixed();
        t_exit_stream();
        t_exit_init();
        t_preload_ignored();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule